// File: doc/BRIEF.md
# Transmit BIST Sequencer with FIFO Arbitration

This block decides, one character slot per clock, what a serial transmitter sends next. Normally it pulls characters from a first-word-fall-through transmit FIFO and passes them on, tagged as data or special. When an active-low, asynchronous test request is seen through a two-stage synchronizer, it stops reading the FIFO and sends a 511-character pseudo-random loop from a 9-bit LFSR instead. The characters left in the FIFO are sent once the request is removed.

A special character always pulls the next FIFO word with it as a data character, and a test request that arrives between the two waits until that data character has gone out. While the test runs, the FIFO can still be written and reset. The full flag and the FIFO reset pass straight through. The empty flag seen by the host changes meaning and marks the first character of each loop.

Top module: `txbist_seq`

## Requirements
- R1: With no test active and no pair pending, a non-empty FIFO is popped (`fifo_rd_o` high for one clock) and its head word appears on the next clock edge. Kind is 2 (special) if word bit 8 is set and 1 (data) otherwise, and `ch_data_o` carries word bits 7:0. An empty FIFO gives kind 0 (idle), data 0 and no pop.
- R2: `bist_en_n` passes through two flip-flops. After it is sampled low at edge k, the output is still unchanged after edges k and k+1, and the first test character appears after edge k+2.
- R3: The first test character of a run has data 0xFF, the low byte of the seed 9'h1FF. Each later one steps the state s to {s[7:0], s[8]^s[4]}, and the sequence repeats every 511 characters.
- R4: While the synchronized request is active and no pair is pending, `fifo_rd_o` stays low and every character has kind 3 (test).
- R5: After a special character, the next FIFO word is sent as kind 1 whatever its bit 8 is, before any test character. Idle slots fill the gap while the FIFO is empty, and a test request does not break the pair.
- R6: Words written before or during a test stay in the FIFO in order. They resume on the first slot after the synchronized request goes inactive, which means output after the third edge after `bist_en_n` is sampled high.
- R7: Without an active test, `empty_flag_o` equals `fifo_empty_i`. With an active test, it is high only while the character on the output is the first of a loop, and low otherwise.
- R8: During a test, `full_flag_o` follows `fifo_full_i` and `fifo_rst_o` follows `host_fifo_rst_i`, so writes fill the FIFO to full and a reset empties it.
- R9: After reset the output is idle (kind 0, data 0) and no read is issued while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en_n | input | 1 | Asynchronous active-low test request |
| fifo_word_i | input | 9 | FIFO head word: bit 8 special flag, bits 7:0 byte |
| fifo_empty_i | input | 1 | FIFO empty status |
| fifo_full_i | input | 1 | FIFO full status |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| host_fifo_rst_i | input | 1 | FIFO reset request from the host |
| fifo_rst_o | output | 1 | FIFO reset to the FIFO |
| empty_flag_o | output | 1 | FIFO empty normally, loop-start marker during test |
| full_flag_o | output | 1 | FIFO full flag to the host |
| ch_kind_o | output | 2 | Character kind: 0 idle, 1 data, 2 special, 3 test |
| ch_data_o | output | 8 | Character byte |

## Verification
The normal path is driven from a vector table that mixes a plain data stream, gaps with the FIFO empty, and special characters followed by a word that also has bit 8 set. This separates pass-through from pair handling and shows that the kind after a special is forced to data. A test run over two full loops with the FIFO empty, filled and then reset checks every character against an independent LFSR model. It also shows that the empty flag follows the loop and not the FIFO, and that no word leaves the FIFO. A test request raised inside a pair whose data word arrives late separates a correct hand-over from one that cuts the pair. Words written during the test must then come out in order, with the exact synchronizer latency.

// File: rtl/txbist_pkg.sv
`timescale 1ns/1ps
package txbist_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_DATA = 2'd1,
        KIND_SPEC = 2'd2,
        KIND_BIST = 2'd3
    } char_kind_e;
endpackage

// File: rtl/txbist_sync.sv
`timescale 1ns/1ps
module txbist_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = async_i;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // R2: the output only takes a value the previous stage already held
    p_sync_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_o) |-> (sync_o == $past(chain_q[STAGES-2])));
endmodule

// File: rtl/txbist_lfsr.sv
`timescale 1ns/1ps
module txbist_lfsr #(
    parameter int                 LFSR_W   = 9,
    parameter int                 CHAR_W   = 8,
    parameter logic [LFSR_W-1:0]  TAP_MASK = 9'h110,
    parameter logic [LFSR_W-1:0]  SEED     = 9'h1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              loop_o
);
    logic [LFSR_W-1:0] state_d, state_q;
    logic              fb;

    always_comb begin
        fb      = ^(state_q & TAP_MASK);
        state_d = SEED;
        if (run_i) state_d = {state_q[LFSR_W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign char_o = state_q[CHAR_W-1:0];
    assign loop_o = (state_q == SEED);

    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    p_lfsr_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> loop_o);
endmodule

// File: rtl/txbist_ctrl.sv
`timescale 1ns/1ps
module txbist_ctrl
    import txbist_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_req_i,
    input  logic [CHAR_W:0]   fifo_word_i,
    input  logic              fifo_empty_i,
    input  logic [CHAR_W-1:0] lfsr_char_i,
    input  logic              lfsr_loop_i,
    output logic              lfsr_run_o,
    output logic              fifo_rd_o,
    output char_kind_e        kind_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              loop_o
);
    typedef struct packed {
        logic              pair;
        char_kind_e        kind;
        logic [CHAR_W-1:0] data;
        logic              loop;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.kind  = KIND_IDLE;
        st_d.data  = '0;
        st_d.loop  = 1'b0;
        fifo_rd_o  = 1'b0;
        lfsr_run_o = 1'b0;
        if (st_q.pair) begin
            if (!fifo_empty_i) begin
                fifo_rd_o = 1'b1;
                st_d.kind = KIND_DATA;
                st_d.data = fifo_word_i[CHAR_W-1:0];
                st_d.pair = 1'b0;
            end
        end else if (bist_req_i) begin
            lfsr_run_o = 1'b1;
            st_d.kind  = KIND_BIST;
            st_d.data  = lfsr_char_i;
            st_d.loop  = lfsr_loop_i;
        end else if (!fifo_empty_i) begin
            fifo_rd_o = 1'b1;
            st_d.kind = fifo_word_i[CHAR_W] ? KIND_SPEC : KIND_DATA;
            st_d.data = fifo_word_i[CHAR_W-1:0];
            st_d.pair = fifo_word_i[CHAR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pair: 1'b0, kind: KIND_IDLE, data: '0, loop: 1'b0};
        else        st_q <= st_d;
    end

    assign kind_o = st_q.kind;
    assign data_o = st_q.data;
    assign loop_o = st_q.loop;

    p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);
    p_bist_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_req_i && !st_q.pair) |=> (st_q.kind == KIND_BIST));
    p_pair_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == KIND_SPEC) |=> (st_q.kind == KIND_DATA || st_q.kind == KIND_IDLE));
    p_loop_bist_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loop |-> (st_q.kind == KIND_BIST));
endmodule

// File: rtl/txbist_seq.sv
`timescale 1ns/1ps
module txbist_seq
    import txbist_pkg::*;
#(
    parameter int                CHAR_W      = 8,
    parameter int                LFSR_W      = 9,
    parameter int                SYNC_STAGES = 2,
    parameter logic [LFSR_W-1:0] TAP_MASK    = 9'h110,
    parameter logic [LFSR_W-1:0] SEED        = 9'h1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_en_n,
    input  logic [CHAR_W:0]   fifo_word_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_full_i,
    output logic              fifo_rd_o,
    input  logic              host_fifo_rst_i,
    output logic              fifo_rst_o,
    output logic              empty_flag_o,
    output logic              full_flag_o,
    output logic [1:0]        ch_kind_o,
    output logic [CHAR_W-1:0] ch_data_o
);
    logic              req_n_sync;
    logic              bist_req;
    logic              lfsr_run;
    logic [CHAR_W-1:0] lfsr_char;
    logic              lfsr_loop;
    logic              loop_mark;
    char_kind_e        kind;

    txbist_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(bist_en_n), .sync_o(req_n_sync));

    assign bist_req = !req_n_sync;

    txbist_lfsr #(.LFSR_W(LFSR_W), .CHAR_W(CHAR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .run_i(lfsr_run), .char_o(lfsr_char), .loop_o(lfsr_loop));

    txbist_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bist_req_i(bist_req),
        .fifo_word_i(fifo_word_i), .fifo_empty_i(fifo_empty_i),
        .lfsr_char_i(lfsr_char), .lfsr_loop_i(lfsr_loop), .lfsr_run_o(lfsr_run),
        .fifo_rd_o(fifo_rd_o), .kind_o(kind), .data_o(ch_data_o), .loop_o(loop_mark));

    assign ch_kind_o    = kind;
    assign empty_flag_o = bist_req ? loop_mark : fifo_empty_i;
    assign full_flag_o  = fifo_full_i;
    assign fifo_rst_o   = host_fifo_rst_i;
endmodule

// File: tb/tb_txbist_seq.sv
`timescale 1ns/1ps
module tb_txbist_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bist_en_n = 1'b1;
    logic       host_rst = 1'b0;
    logic       push = 1'b0;
    logic [8:0] push_word = '0;
    logic [8:0] fifo_word;
    logic       fifo_empty, fifo_full, fifo_rd, fifo_rst;
    logic       empty_flag, full_flag;
    logic [1:0] ch_kind;
    logic [7:0] ch_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    txbist_seq dut (
        .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n),
        .fifo_word_i(fifo_word), .fifo_empty_i(fifo_empty), .fifo_full_i(fifo_full),
        .fifo_rd_o(fifo_rd), .host_fifo_rst_i(host_rst), .fifo_rst_o(fifo_rst),
        .empty_flag_o(empty_flag), .full_flag_o(full_flag),
        .ch_kind_o(ch_kind), .ch_data_o(ch_data));

    // FIFO model, first word falls through
    logic [8:0] mem [16];
    logic [4:0] wp = '0, rp = '0;
    assign fifo_empty = (wp == rp);
    assign fifo_full  = ((wp - rp) == 5'd16);
    assign fifo_word  = mem[rp[3:0]];

    always @(posedge clk) begin
        if (fifo_rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !fifo_full) begin
                mem[wp[3:0]] <= push_word;
                wp <= wp + 5'd1;
            end
            if (fifo_rd && !fifo_empty) rp <= rp + 5'd1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic       push;
        logic [8:0] word;
        logic [1:0] kind;
        logic [7:0] data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 9'h03C, 2'd1, 8'h3C},
        '{1'b1, 9'h0A5, 2'd1, 8'hA5},
        '{1'b1, 9'h1BC, 2'd2, 8'hBC},
        '{1'b1, 9'h011, 2'd1, 8'h11},
        '{1'b0, 9'h000, 2'd0, 8'h00},
        '{1'b1, 9'h0FF, 2'd1, 8'hFF},
        '{1'b1, 9'h1F7, 2'd2, 8'hF7},
        '{1'b0, 9'h000, 2'd0, 8'h00},
        '{1'b1, 9'h155, 2'd1, 8'h55},
        '{1'b1, 9'h100, 2'd2, 8'h00},
        '{1'b1, 9'h000, 2'd1, 8'h00},
        '{1'b1, 9'h07E, 2'd1, 8'h7E}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        summary();
    end

    initial begin
        logic [8:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(ch_kind == 2'd0, "R9 kind", 32'(ch_kind), 0);
        chk(ch_data == 8'h00, "R9 data", 32'(ch_data), 0);
        chk(!fifo_rd, "R9 no read", 32'(fifo_rd), 0);
        chk(empty_flag, "R9 empty flag", 32'(empty_flag), 1);

        // R1 R5 table walk: entry i shows up two negedges after it is driven
        for (int i = 0; i <= NV; i++) begin
            if (i < NV) begin
                push      = VEC[i].push;
                push_word = VEC[i].word;
            end else begin
                push = 1'b0;
            end
            @(negedge clk);
            if (i >= 1) begin
                chk(ch_kind == VEC[i-1].kind, "R1/R5 table kind", 32'(ch_kind), 32'(VEC[i-1].kind));
                chk(ch_data == VEC[i-1].data, "R1 table data", 32'(ch_data), 32'(VEC[i-1].data));
                chk(empty_flag == fifo_empty, "R7 normal empty flag", 32'(empty_flag), 32'(fifo_empty));
            end
        end
        push = 1'b0;
        @(negedge clk);

        // R2 latency of the test request
        bist_en_n = 1'b0;
        @(negedge clk);
        chk(ch_kind == 2'd0, "R2 first edge", 32'(ch_kind), 0);
        @(negedge clk);
        chk(ch_kind == 2'd0, "R2 second edge", 32'(ch_kind), 0);
        @(negedge clk);

        // R3 R4 R7 R8 two loops plus one character
        s = 9'h1FF;
        for (int k = 0; k < 1023; k++) begin
            chk(ch_kind == 2'd3, "R4 test kind", 32'(ch_kind), 3);
            chk(ch_data == s[7:0], "R3 sequence", 32'(ch_data), 32'(s[7:0]));
            chk(empty_flag == ((k % 511) == 0), "R7 loop marker", 32'(empty_flag), 32'((k % 511) == 0));
            chk(!fifo_rd, "R4 no read", 32'(fifo_rd), 0);
            if (k == 30) chk(full_flag, "R8 full during test", 32'(full_flag), 1);
            if (k == 42) chk(!full_flag && fifo_empty, "R8 reset during test", 32'(full_flag), 0);
            s = {s[7:0], s[8] ^ s[4]};
            push      = (k >= 10 && k < 26) || k == 50 || k == 51;
            push_word = (k == 50) ? 9'h0C1 : (k == 51) ? 9'h0C2 : 9'(9'h040 + k);
            host_rst  = (k == 40);
            if (k == 40) begin
                #1;
                chk(fifo_rst, "R8 reset passes", 32'(fifo_rst), 1);
            end
            @(negedge clk);
        end
        push = 1'b0;
        host_rst = 1'b0;

        // R6 resume after release
        bist_en_n = 1'b1;
        @(negedge clk);
        chk(ch_kind == 2'd3, "R6 still test 1", 32'(ch_kind), 3);
        @(negedge clk);
        chk(ch_kind == 2'd3, "R6 still test 2", 32'(ch_kind), 3);
        @(negedge clk);
        chk(ch_kind == 2'd1 && ch_data == 8'hC1, "R6 first kept word", 32'(ch_data), 32'hC1);
        @(negedge clk);
        chk(ch_kind == 2'd1 && ch_data == 8'hC2, "R6 second kept word", 32'(ch_data), 32'hC2);
        @(negedge clk);
        chk(ch_kind == 2'd0, "R1 idle after drain", 32'(ch_kind), 0);

        // R5 test request inside a pair whose data word arrives late
        push = 1'b1; push_word = 9'h1B5;
        @(negedge clk);
        push = 1'b0; bist_en_n = 1'b0;
        @(negedge clk);
        chk(ch_kind == 2'd2 && ch_data == 8'hB5, "R5 special out", 32'(ch_kind), 2);
        @(negedge clk);
        chk(ch_kind == 2'd0, "R5 waits idle", 32'(ch_kind), 0);
        push = 1'b1; push_word = 9'h1D2;
        @(negedge clk);
        chk(ch_kind == 2'd0, "R5 waits idle 2", 32'(ch_kind), 0);
        push = 1'b1; push_word = 9'h0E7;
        @(negedge clk);
        push = 1'b0;
        chk(ch_kind == 2'd1 && ch_data == 8'hD2, "R5 pair data before test", 32'(ch_data), 32'hD2);
        chk(!fifo_rd, "R4 held word not read", 32'(fifo_rd), 0);
        @(negedge clk);
        chk(ch_kind == 2'd3 && ch_data == 8'hFF, "R3 restart at seed", 32'(ch_data), 32'hFF);
        chk(empty_flag, "R7 loop start marker", 32'(empty_flag), 1);
        bist_en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ch_kind == 2'd3, "R6 test until sync clears", 32'(ch_kind), 3);
        @(negedge clk);
        chk(ch_kind == 2'd1 && ch_data == 8'hE7, "R6 held word resumes", 32'(ch_data), 32'hE7);

        summary();
    end
endmodule